// File: doc/BRIEF.md
# Byte-Wide NAND Flash Strobe Controller

This block connects a simple register bus to a byte-wide raw NAND flash device. Software drives the command-latch, address-latch, chip-select and write-permit lines of the flash by writing bits of a pin-control register. Each access to the single data register becomes one timed bus cycle on the flash side. A write puts a byte on the data lines under a write strobe. A read captures a byte under a read strobe. A timing register sets how long the strobe stays active and how long the bus is held afterwards, both counted in system clocks.

A status register shows the device's ready/busy line after a two-stage synchronizer. A self-clearing control bit restarts the controller's state. A two-bit checksum field in the pin-control register has four codes: idle, clear, fold and drain. In fold mode the controller folds every byte that passes through the data register into six parity lanes. In drain mode, successive reads of the data register return the lanes in order, with no flash cycle. The folding rule is a plain per-lane XOR that stands in for a real parity code.

The register bus is a request/acknowledge handshake. The master holds `req_i` until it sees `ack_o`. While a flash cycle is running, no new request is taken, and none is lost.

Top module: `nfc_ctrl`

## Requirements
- R1: Register address 1 holds the pin-control bits, and they read back as written.
  - bit0 drives `fl_cle_o` and bit1 drives `fl_ale_o`.
  - bit2 set drives `fl_ce_n_o` low, and bit3 set drives `fl_wp_n_o` high.
  - bit4 is a stored bus-split option.
  - bits [6:5] are the checksum mode.
  - After reset every bit is 0.
- R2: Register address 2 reads the busy flag in bit0, all other bits 0. The flag is the inverse of `fl_rb_i`, which is 1 when the device is ready. It follows the pin within three clocks.
- R3: Writing 1 to bit0 of address 4 starts a soft reset.
  - Bit0 of address 4 reads 1 for RST_CYCLES clocks, then 0.
  - The pin-control register, the parity lanes and both lane pointers return to 0.
  - The timing register keeps its value.
- R4: Address 3 is the timing register: hold count in bits [7:4] and strobe count in bits [3:0]. It reads back as written, and a count of 0 acts as 1.
- R5: A write to address 0 is accepted on a clock edge.
  - `ack_o` is high in the cycle after that edge.
  - `fl_we_n_o` is low for exactly the strobe count of cycles, starting then.
  - `fl_dq_oe_o` is high with the byte on `fl_dq_o` for the strobe count plus the hold count.
- R6: A read from address 0 outside drain mode drives `fl_re_n_o` low for the strobe count of cycles. The byte on `fl_dq_i` is captured at the edge that ends the strobe. `ack_o`, with that byte on `rdata_o`, comes in the cycle after that edge.
- R7: While a flash cycle is running (strobe plus hold), no request is accepted. The first edge that can accept one comes one clock after the hold ends. Every access completes, and `ack_o` is a single-cycle pulse.
- R8: The checksum mode codes are 0 idle, 1 fold, 2 drain and 3 clear.
  - Code 3 zeroes all six lanes and both pointers.
  - In fold mode, each data byte written or read is XORed into lane k, where k counts data bytes since the clear, modulo 6.
  - In idle mode, data bytes leave the lanes unchanged.
- R9: In drain mode (code 2), reads of address 0 return the lanes in the order 0 to 5, wrapping. Each read is acknowledged in the cycle after acceptance and makes no strobe.
- R10: Accesses to addresses other than 0 are acknowledged in the cycle after acceptance, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Register access request, held until acknowledge |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-cycle access acknowledge |
| rdata_o | output | DATA_W | Read data, valid with acknowledge |
| fl_cle_o | output | 1 | Flash command-latch enable |
| fl_ale_o | output | 1 | Flash address-latch enable |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_wp_n_o | output | 1 | Flash write protect, active low |
| fl_we_n_o | output | 1 | Flash write strobe, active low |
| fl_re_n_o | output | 1 | Flash read strobe, active low |
| fl_dq_o | output | DATA_W | Flash data out |
| fl_dq_oe_o | output | 1 | Flash data output enable |
| fl_dq_i | input | DATA_W | Flash data in |
| fl_rb_i | input | 1 | Flash ready/busy, 1 = ready |

## Verification
The hardest case to reach is a request that arrives while the previous flash cycle is still in its hold phase. That is the only case that shows the stall rule. The bench issues a data access in the clock right after a posted write's acknowledge, with long hold counts. Its model predicts the delayed acceptance edge and the strobe window that follows, clock by clock. The parity lanes can only be observed by draining them, so the bench drains them twice: once after folding a mix of written and read bytes, and again after data traffic in idle mode. The second drain must return the same values.

// File: rtl/nfc_pkg.sv
// Shared register map, pin-control bit positions and checksum mode codes.
package nfc_pkg;
    localparam int REG_DATA   = 0;
    localparam int REG_MODE   = 1;
    localparam int REG_STATUS = 2;
    localparam int REG_TIMING = 3;
    localparam int REG_RESET  = 4;

    localparam int MB_CLE = 0;
    localparam int MB_ALE = 1;
    localparam int MB_CE  = 2;
    localparam int MB_WEN = 3;
    localparam int MB_SPL = 4;
    localparam int MB_ECC = 5;
    localparam int MODE_W = 7;

    typedef enum logic [1:0] {
        ECC_IDLE  = 2'b00,
        ECC_FOLD  = 2'b01,
        ECC_DRAIN = 2'b10,
        ECC_CLEAR = 2'b11
    } ecc_mode_e;
endpackage

// File: rtl/nfc_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2; the output resets to RST_VAL.
module nfc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_q;

    // Shift the sampled level through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= {STAGES{RST_VAL}};
        else        sr_q <= {sr_q[STAGES-2:0], d_i};
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/nfc_strobe.sv
// Flash strobe engine: one read or write cycle per start pulse.
// The strobe phase lasts max(pulse,1) clocks and the hold phase max(hold,1) clocks.
// Assumes start_i is only raised while busy_o is low.
module nfc_strobe #(
    parameter int DW = 8,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [TW-1:0] pulse_i,
    input  logic [TW-1:0] hold_i,
    input  logic [DW-1:0] dq_i,
    output logic          busy_o,
    output logic          we_n_o,
    output logic          re_n_o,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o,
    output logic          rd_done_o,
    output logic [DW-1:0] rd_data_o
);
    typedef enum logic [1:0] {ST_IDLE, ST_STB, ST_HLD} st_e;

    st_e           st_q;
    logic [TW-1:0] cnt_q;
    logic          rd_q;
    logic [DW-1:0] dout_q;

    function automatic logic [TW-1:0] last_idx(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    // Sequence strobe then hold, and capture the read byte at strobe end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            rd_q      <= 1'b0;
            dout_q    <= '0;
            rd_done_o <= 1'b0;
            rd_data_o <= '0;
        end else begin
            rd_done_o <= 1'b0;
            case (st_q)
                ST_IDLE: if (start_i) begin
                    st_q   <= ST_STB;
                    cnt_q  <= last_idx(pulse_i);
                    rd_q   <= rd_i;
                    dout_q <= wdata_i;
                end
                ST_STB: if (cnt_q == '0) begin
                    st_q  <= ST_HLD;
                    cnt_q <= last_idx(hold_i);
                    if (rd_q) begin
                        rd_data_o <= dq_i;
                        rd_done_o <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                ST_HLD: if (cnt_q == '0) st_q <= ST_IDLE;
                        else             cnt_q <= cnt_q - 1'b1;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (st_q != ST_IDLE);
    assign we_n_o  = !((st_q == ST_STB) && !rd_q);
    assign re_n_o  = !((st_q == ST_STB) && rd_q);
    assign dq_oe_o = busy_o && !rd_q;
    assign dq_o    = dout_q;

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    assert_capture_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |-> $past(!re_n_o));
endmodule

// File: rtl/nfc_ecc.sv
// Six-lane parity accumulator with in-order readout.
// Folds bytes in fold mode, steps the read pointer in drain mode, and zeroes on clear.
module nfc_ecc
    import nfc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LANES = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  ecc_mode_e     mode_i,
    input  logic          byte_vld_i,
    input  logic [DW-1:0] byte_i,
    input  logic          rd_next_i,
    output logic [DW-1:0] par_o
);
    localparam int IW = $clog2(LANES);

    logic [DW-1:0] lane_q [LANES];
    logic [IW-1:0] fold_ptr, out_ptr;

    // Clear, fold bytes into the current lane, or advance the readout.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || mode_i == ECC_CLEAR) begin
            for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
            fold_ptr <= '0;
            out_ptr  <= '0;
        end else begin
            if (mode_i == ECC_FOLD && byte_vld_i) begin
                lane_q[fold_ptr] <= lane_q[fold_ptr] ^ byte_i;
                fold_ptr <= (fold_ptr == IW'(LANES-1)) ? '0 : fold_ptr + 1'b1;
            end
            if (mode_i == ECC_DRAIN && rd_next_i)
                out_ptr <= (out_ptr == IW'(LANES-1)) ? '0 : out_ptr + 1'b1;
        end
    end

    assign par_o = lane_q[out_ptr];

    assert_idle_no_fold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && mode_i == ECC_IDLE && !clr_i) |=> $stable(fold_ptr));
    assert_drain_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_next_i && mode_i == ECC_DRAIN && !clr_i) |=> (out_ptr != $past(out_ptr)));
endmodule

// File: rtl/nfc_ctrl.sv
// NAND flash byte-interface controller top: register file, bus handshake,
// pin control, strobe engine and parity lanes.
// Assumes the master holds req_i stable until ack_o and DATA_W >= 8.
module nfc_ctrl
    import nfc_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 8,
    parameter int RST_CYCLES = 4,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              fl_cle_o,
    output logic              fl_ale_o,
    output logic              fl_ce_n_o,
    output logic              fl_wp_n_o,
    output logic              fl_we_n_o,
    output logic              fl_re_n_o,
    output logic [DATA_W-1:0] fl_dq_o,
    output logic              fl_dq_oe_o,
    input  logic [DATA_W-1:0] fl_dq_i,
    input  logic              fl_rb_i
);
    localparam int TW = DATA_W / 2;
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic [MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] tim_q;
    logic              rst_busy;
    logic [RW-1:0]     rst_cnt;
    logic              ack_q;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              rb_s;
    ecc_mode_e         ecc_mode;
    logic              eng_busy, eng_done;
    logic [DATA_W-1:0] eng_rdata, par;
    logic              accept, is_data, drain_rd, eng_start;

    assign ecc_mode  = ecc_mode_e'(mode_q[MB_ECC+1:MB_ECC]);
    assign accept    = req_i && !ack_q && !eng_done && !eng_busy;
    assign is_data   = (addr_i == ADDR_W'(REG_DATA));
    assign drain_rd  = is_data && !we_i && (ecc_mode == ECC_DRAIN);
    assign eng_start = accept && is_data && !drain_rd;

    nfc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_rb_sync (
        .clk(clk), .rst_n(rst_n), .d_i(fl_rb_i), .q_o(rb_s)
    );

    nfc_strobe #(.DW(DATA_W), .TW(TW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .start_i(eng_start), .rd_i(!we_i),
        .wdata_i(wdata_i), .pulse_i(tim_q[TW-1:0]), .hold_i(tim_q[2*TW-1:TW]),
        .dq_i(fl_dq_i), .busy_o(eng_busy), .we_n_o(fl_we_n_o), .re_n_o(fl_re_n_o),
        .dq_o(fl_dq_o), .dq_oe_o(fl_dq_oe_o), .rd_done_o(eng_done), .rd_data_o(eng_rdata)
    );

    nfc_ecc #(.DW(DATA_W), .LANES(6)) u_ecc (
        .clk(clk), .rst_n(rst_n), .clr_i(rst_busy), .mode_i(ecc_mode),
        .byte_vld_i((eng_start && we_i) || eng_done),
        .byte_i(eng_done ? eng_rdata : wdata_i),
        .rd_next_i(accept && drain_rd), .par_o(par)
    );

    // Select the read value of the addressed register.
    always_comb begin
        rdata_d = '0;
        case (addr_i)
            ADDR_W'(REG_DATA):   rdata_d = par;
            ADDR_W'(REG_MODE):   rdata_d[MODE_W-1:0] = mode_q;
            ADDR_W'(REG_STATUS): rdata_d[0] = !rb_s;
            ADDR_W'(REG_TIMING): rdata_d = tim_q;
            ADDR_W'(REG_RESET):  rdata_d[0] = rst_busy;
            default:             rdata_d = '0;
        endcase
    end

    // Register writes, soft reset sequencing and the register-side acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            tim_q    <= '0;
            rst_busy <= 1'b0;
            rst_cnt  <= '0;
            ack_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            ack_q <= accept && !(is_data && !we_i && !drain_rd);
            if (accept && !we_i) rdata_q <= rdata_d;
            if (rst_busy) begin
                mode_q <= '0;
                if (rst_cnt == '0) rst_busy <= 1'b0;
                else               rst_cnt  <= rst_cnt - 1'b1;
            end
            if (accept && we_i) begin
                case (addr_i)
                    ADDR_W'(REG_MODE):   if (!rst_busy) mode_q <= wdata_i[MODE_W-1:0];
                    ADDR_W'(REG_TIMING): tim_q <= wdata_i;
                    ADDR_W'(REG_RESET):  if (wdata_i[0]) begin
                        rst_busy <= 1'b1;
                        rst_cnt  <= RW'(RST_CYCLES - 1);
                        mode_q   <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ack_o     = ack_q | eng_done;
    assign rdata_o   = eng_done ? eng_rdata : rdata_q;
    assign fl_cle_o  = mode_q[MB_CLE];
    assign fl_ale_o  = mode_q[MB_ALE];
    assign fl_ce_n_o = !mode_q[MB_CE];
    assign fl_wp_n_o = mode_q[MB_WEN];

    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n_o && !fl_re_n_o));
    assert_write_drives_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n_o |-> fl_dq_oe_o);
    assert_reset_clears_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_busy) |-> (mode_q == '0));
endmodule

// File: tb/sim_nfc_ctrl.sv
// Bench for nfc_ctrl: behavioural model of strobe windows and parity lanes,
// compared at every falling edge, plus per-access checks.
module sim_nfc_ctrl;
    localparam int CLK_NS = 10;
    localparam int RSTC   = 4;

    logic       clk = 0, rst_n = 0, req = 0, we = 0, rb = 1;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, dq_in = 0;
    logic       ack, cle, ale, ce_n, wp_n, we_n, re_n, oe;
    logic [7:0] rdata, dq_out;

    nfc_ctrl #(.ADDR_W(3), .DATA_W(8), .RST_CYCLES(RSTC), .SYNC_STG(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .ack_o(ack), .rdata_o(rdata), .fl_cle_o(cle), .fl_ale_o(ale), .fl_ce_n_o(ce_n),
        .fl_wp_n_o(wp_n), .fl_we_n_o(we_n), .fl_re_n_o(re_n), .fl_dq_o(dq_out),
        .fl_dq_oe_o(oe), .fl_dq_i(dq_in), .fl_rb_i(rb)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct { int a; int pw; int h; bit rd; logic [7:0] d; } win_t;
    win_t wq[$];
    int   cyc = 0, free_at = 0, errors = 0, checks = 0;
    bit   done = 0;
    logic [7:0] m_mode = 0, m_tim = 0;
    logic [7:0] m_lane [6];
    int   m_fold = 0, m_out = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic clear_lanes();
        for (int i = 0; i < 6; i++) m_lane[i] = 0;
        m_fold = 0;
        m_out  = 0;
    endtask

    // Per-clock comparison of the strobe pins against the modelled windows (R5, R6, R7).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic ew, er, eo;
            logic [7:0] ed;
            ew = 1; er = 1; eo = 0; ed = 0;
            foreach (wq[i]) begin
                if (cyc >= wq[i].a && cyc < wq[i].a + wq[i].pw) begin
                    if (wq[i].rd) er = 0; else ew = 0;
                end
                if (!wq[i].rd && cyc >= wq[i].a && cyc < wq[i].a + wq[i].pw + wq[i].h) begin
                    eo = 1;
                    ed = wq[i].d;
                end
            end
            chk(we_n === ew && re_n === er && oe === eo && (!eo || dq_out === ed),
                "R5/R6/R7 strobe window", {we_n, re_n, oe, dq_out}, {ew, er, eo, ed});
        end
    end

    // One register access; the model predicts the accept edge and the acknowledge cycle.
    task automatic access(input bit wr, input logic [2:0] ad, input logic [7:0] wd,
                          output logic [7:0] rd);
        int r, a, pw, h, exp_ack;
        bit drain;
        @(negedge clk);
        req = 1; we = wr; addr = ad; wdata = wd;
        r = cyc + 1;
        a = (r > free_at) ? r : free_at;
        drain = (m_mode[6:5] == 2'b10);
        exp_ack = a;
        if (ad == 0 && !(drain && !wr)) begin
            pw = (m_tim[3:0] == 0) ? 1 : int'(m_tim[3:0]);
            h  = (m_tim[7:4] == 0) ? 1 : int'(m_tim[7:4]);
            wq.push_back('{a, pw, h, !wr, wd});
            free_at = a + pw + h + 1;
            if (!wr) exp_ack = a + pw;
            if (m_mode[6:5] == 2'b01) begin
                m_lane[m_fold] ^= wr ? wd : dq_in;
                m_fold = (m_fold + 1) % 6;
            end
        end
        @(negedge clk);
        while (!ack) @(negedge clk);
        chk(cyc == exp_ack, "R5/R6/R7/R10 ack timing", cyc, exp_ack);
        rd = rdata;
        req = 0;
        if (wr && ad == 1) begin
            m_mode = wd & 8'h7f;
            if (m_mode[6:5] == 2'b11) clear_lanes();
        end
        if (wr && ad == 3) m_tim = wd;
        if (wr && ad == 4 && wd[0]) begin
            m_mode = 0;
            clear_lanes();
        end
    endtask

    task automatic rd_reg(input logic [2:0] ad, input int exp, input string rq);
        logic [7:0] v;
        access(0, ad, 8'h00, v);
        chk(v === exp[7:0], rq, v, exp);
    endtask

    task automatic wr_reg(input logic [2:0] ad, input logic [7:0] v);
        logic [7:0] unused;
        access(1, ad, v, unused);
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        clear_lanes();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: pins after reset
        chk({cle, ale, ce_n, wp_n} === 4'b0010, "R1 reset pins", {cle, ale, ce_n, wp_n}, 4'b0010);
        chk(ack === 0, "R10 no ack at reset", ack, 0);
        rd_reg(3, 0, "R4 timing reset value");
        rd_reg(7, 0, "R10 unmapped reads zero");

        // R4 zero counts act as one; R5 write, R6 read
        wr_reg(3, 8'h00);
        wr_reg(0, 8'hA5);
        dq_in = 8'h3C;
        rd_reg(0, 8'h3C, "R6 read capture 1/1");
        wr_reg(3, 8'h32);
        rd_reg(3, 8'h32, "R4 timing readback");
        wr_reg(0, 8'h5A);
        dq_in = 8'hC3;
        rd_reg(0, 8'hC3, "R6 read capture 2/3");
        wr_reg(3, 8'h1F);
        wr_reg(0, 8'h11);

        // R1 pin control and readback
        wr_reg(1, 8'h0F);
        chk({cle, ale, ce_n, wp_n} === 4'b1101, "R1 all pins set", {cle, ale, ce_n, wp_n}, 4'b1101);
        wr_reg(1, 8'h01);
        chk({cle, ale, ce_n, wp_n} === 4'b1010, "R1 cle only", {cle, ale, ce_n, wp_n}, 4'b1010);
        wr_reg(1, 8'h12);
        rd_reg(1, 8'h12, "R1 bus-split bit readback");

        // R2 busy flag through the synchronizer
        @(negedge clk); rb = 0;
        repeat (4) @(negedge clk);
        rd_reg(2, 1, "R2 busy when rb low");
        rb = 1;
        repeat (4) @(negedge clk);
        rd_reg(2, 0, "R2 ready when rb high");

        // R7 stall: back-to-back accesses during long hold
        wr_reg(3, 8'hF2);
        wr_reg(0, 8'h81);
        wr_reg(0, 8'h42);
        dq_in = 8'h99;
        rd_reg(0, 8'h99, "R7 read after stalled write");
        rd_reg(3, 8'hF2, "R7 register read after stall");

        // R8 fold, R9 drain
        wr_reg(3, 8'h11);
        wr_reg(1, 8'h60);
        wr_reg(1, 8'h00);
        wr_reg(1, 8'h20);
        for (int i = 0; i < 8; i++) wr_reg(0, 8'(8'h13 * (i + 1)));
        dq_in = 8'h6E; rd_reg(0, 8'h6E, "R8 read during fold");
        dq_in = 8'hB7; rd_reg(0, 8'hB7, "R8 read during fold");
        wr_reg(1, 8'h40);
        for (int i = 0; i < 6; i++) begin
            int e;
            e = m_lane[m_out]; m_out = (m_out + 1) % 6;
            rd_reg(0, e, "R9 drain lane (R8 fold values)");
        end
        // R8 idle: data traffic leaves lanes unchanged
        wr_reg(1, 8'h00);
        wr_reg(0, 8'hFF);
        dq_in = 8'h55; rd_reg(0, 8'h55, "R8 idle read");
        wr_reg(1, 8'h40);
        for (int i = 0; i < 6; i++) begin
            int e;
            e = m_lane[m_out]; m_out = (m_out + 1) % 6;
            rd_reg(0, e, "R8 idle leaves lanes (drain R9)");
        end

        // R3 soft reset
        wr_reg(1, 8'h2F);
        wr_reg(4, 8'h01);
        rd_reg(4, 1, "R3 reset bit set during reset");
        repeat (RSTC + 2) @(negedge clk);
        rd_reg(4, 0, "R3 reset bit self-clears");
        rd_reg(1, 0, "R3 mode cleared");
        chk({cle, ale, ce_n, wp_n} === 4'b0010, "R3 pins cleared", {cle, ale, ce_n, wp_n}, 4'b0010);
        rd_reg(3, 8'h11, "R3 timing kept");
        wr_reg(1, 8'h40);
        rd_reg(0, 0, "R3 lanes cleared");

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule